// File: doc/BRIEF.md
# Platform Timebase Counter with Compare

This block keeps the platform's 64-bit notion of time. One count is 10 ns, but the counter does not advance every 10 ns. An update strobe arrives at a slower rate, at least 10 MHz, and each strobe adds a step. The step is the number of 10 ns units that have elapsed since the previous strobe, which is 10 at the minimum rate. The time value can only be read, and it never repeats or moves backward. The only exception is the wrap from all ones to zero, which at this resolution is thousands of years away.

Next to the counter sits one compare register that supervisor software can write. A level-sensitive supervisor timer interrupt is raised while the time value is at or past the compare value, using an unsigned comparison. Software clears the interrupt by writing a later deadline. No machine-level agent is involved.

Top module: `tbc_timebase`

## Requirements
- R1: While reset (active high, synchronous) is sampled high, the time output becomes 0, the compare register becomes all ones and the interrupt output becomes 0.
- R2: At a clock edge where the update strobe is high, the time value grows by the step input (4 bits, unsigned value 1 to 15), modulo 2^TIME_W.
- R3: A step input of 0 sampled with the strobe is treated as a step of 1, so every strobe makes time strictly larger.
- R4: At an edge without the strobe, the time value stays unchanged whatever the step input carries.
- R5: The interrupt output is registered. After every edge it equals (time >= compare) as an unsigned TIME_W-bit comparison of the values both registers hold after that same edge.
- R6: A compare write is captured at the next clock edge. Writing a value above the current time drops the interrupt at that same edge, and writing a value at or below it raises the interrupt.
- R7: The counter wraps from all ones to a small value, the remainder of the sum. After the wrap the interrupt follows the wrapped value.
- R8: The comparison is unsigned. A compare value with its top bit set is larger than any small time value and raises no interrupt.
- R9: When a strobe and a compare write fall on the same edge, both take effect at that edge, and the interrupt is judged on the new time against the new compare value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | Update strobe; advance time on this edge |
| step_i | input | STEP_W (4) | Number of 10 ns units to add; 0 is treated as 1 |
| cmp_we_i | input | 1 | Compare-register write enable |
| cmp_wdata_i | input | TIME_W (64) | New compare value |
| time_o | output | TIME_W (64) | Current time in 10 ns units |
| sup_tmr_irq_o | output | 1 | Level supervisor timer interrupt |

## Verification
The bench targets the equal case, where time lands exactly on the compare value. A design that used a strict greater-than would hold the interrupt low there. A zero step is applied with the strobe, and a design without the clamp would let time stand still on an update. A compare value with its top bit set catches a signed comparison, which would raise a spurious interrupt. A strobe and a compare write on the same edge, plus a narrow 8-bit instance driven across its wrap, expose an interrupt that is computed from stale register values or that sticks after the wrap.

// File: rtl/tbc_pkg.sv
package tbc_pkg;
    localparam int TIME_W_DEF = 64;
    localparam int STEP_W_DEF = 4;

    typedef enum logic {
        ADV_HOLD = 1'b0,
        ADV_STEP = 1'b1
    } adv_e;

    typedef struct packed {
        adv_e adv;
        logic clamped;
    } upd_kind_t;
endpackage

// File: rtl/tbc_step_sel.sv
module tbc_step_sel
    import tbc_pkg::*;
#(
    parameter int STEP_W = STEP_W_DEF
) (
    input  logic              tick_i,
    input  logic [STEP_W-1:0] step_i,
    output upd_kind_t         kind_o,
    output logic [STEP_W-1:0] step_eff_o
);
    localparam logic [STEP_W-1:0] MIN_STEP = STEP_W'(1);

    always_comb begin
        kind_o.adv     = tick_i ? ADV_STEP : ADV_HOLD;
        kind_o.clamped = (step_i == '0);
        step_eff_o     = kind_o.clamped ? MIN_STEP : step_i;
    end
endmodule

// File: rtl/tbc_counter.sv
module tbc_counter
    import tbc_pkg::*;
#(
    parameter int TIME_W = TIME_W_DEF,
    parameter int STEP_W = STEP_W_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  upd_kind_t         kind_i,
    input  logic [STEP_W-1:0] step_eff_i,
    output logic [TIME_W-1:0] time_d_o,
    output logic [TIME_W-1:0] time_q_o
);
    always_comb begin
        if (kind_i.adv == ADV_STEP)
            time_d_o = time_q_o + TIME_W'(step_eff_i);
        else
            time_d_o = time_q_o;
    end

    always_ff @(posedge clk) begin
        if (rst) time_q_o <= '0;
        else     time_q_o <= time_d_o;
    end
endmodule

// File: rtl/tbc_compare.sv
module tbc_compare
    import tbc_pkg::*;
#(
    parameter int TIME_W = TIME_W_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we_i,
    input  logic [TIME_W-1:0] wdata_i,
    input  logic [TIME_W-1:0] time_d_i,
    output logic [TIME_W-1:0] cmp_q_o,
    output logic              irq_o
);
    logic [TIME_W-1:0] cmp_d;

    assign cmp_d = we_i ? wdata_i : cmp_q_o;

    always_ff @(posedge clk) begin
        if (rst) begin
            cmp_q_o <= '1;
            irq_o   <= 1'b0;
        end else begin
            cmp_q_o <= cmp_d;
            irq_o   <= (time_d_i >= cmp_d);
        end
    end
endmodule

// File: rtl/tbc_timebase.sv
module tbc_timebase
    import tbc_pkg::*;
#(
    parameter int TIME_W = TIME_W_DEF,
    parameter int STEP_W = STEP_W_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_i,
    input  logic [STEP_W-1:0] step_i,
    input  logic              cmp_we_i,
    input  logic [TIME_W-1:0] cmp_wdata_i,
    output logic [TIME_W-1:0] time_o,
    output logic              sup_tmr_irq_o
);
    upd_kind_t         kind;
    logic [STEP_W-1:0] step_eff;
    logic [TIME_W-1:0] time_d;
    logic [TIME_W-1:0] cmp_q;

    tbc_step_sel #(.STEP_W(STEP_W)) u_sel (
        .tick_i     (tick_i),
        .step_i     (step_i),
        .kind_o     (kind),
        .step_eff_o (step_eff)
    );

    tbc_counter #(.TIME_W(TIME_W), .STEP_W(STEP_W)) u_cnt (
        .clk        (clk),
        .rst        (rst),
        .kind_i     (kind),
        .step_eff_i (step_eff),
        .time_d_o   (time_d),
        .time_q_o   (time_o)
    );

    tbc_compare #(.TIME_W(TIME_W)) u_cmp (
        .clk      (clk),
        .rst      (rst),
        .we_i     (cmp_we_i),
        .wdata_i  (cmp_wdata_i),
        .time_d_i (time_d),
        .cmp_q_o  (cmp_q),
        .irq_o    (sup_tmr_irq_o)
    );
endmodule

// File: rtl/tbc_timebase_chk.sv
module tbc_timebase_chk #(
    parameter int TIME_W = 64,
    parameter int STEP_W = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              tick_i,
    input logic [STEP_W-1:0] step_i,
    input logic              cmp_we_i,
    input logic [TIME_W-1:0] cmp_wdata_i,
    input logic [TIME_W-1:0] time_o,
    input logic [TIME_W-1:0] cmp_q,
    input logic              sup_tmr_irq_o
);
    localparam logic [TIME_W-1:0] STEP_MAX = TIME_W'((1 << STEP_W) - 1);

    a_r1_reset_state: assert property (@(posedge clk)
        rst |=> (time_o == '0) && (cmp_q == '1) && !sup_tmr_irq_o);

    a_r2_step_range: assert property (@(posedge clk) disable iff (rst)
        tick_i |=> ((time_o - $past(time_o)) != '0) &&
                   ((time_o - $past(time_o)) <= STEP_MAX));

    a_r3_zero_clamp: assert property (@(posedge clk) disable iff (rst)
        (tick_i && step_i == '0) |=> (time_o == $past(time_o) + TIME_W'(1)));

    a_r4_hold: assert property (@(posedge clk) disable iff (rst)
        !tick_i |=> $stable(time_o));

    a_r5_irq_level: assert property (@(posedge clk) disable iff (rst)
        sup_tmr_irq_o == (time_o >= cmp_q));

    a_r6_write_clears: assert property (@(posedge clk) disable iff (rst)
        (cmp_we_i && !tick_i && cmp_wdata_i > time_o) |=> !sup_tmr_irq_o);
endmodule

bind tbc_timebase tbc_timebase_chk #(.TIME_W(TIME_W), .STEP_W(STEP_W)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .tick_i        (tick_i),
    .step_i        (step_i),
    .cmp_we_i      (cmp_we_i),
    .cmp_wdata_i   (cmp_wdata_i),
    .time_o        (time_o),
    .cmp_q         (cmp_q),
    .sup_tmr_irq_o (sup_tmr_irq_o)
);

// File: tb/sim_tbc_timebase.sv
module sim_tbc_timebase;
    typedef struct packed {
        logic        tick;
        logic [3:0]  step;
        logic        we;
        logic [63:0] wdata;
        logic [63:0] exp_time;
        logic        exp_irq;
    } vec_t;

    localparam int NV = 11;
    localparam vec_t VECS [0:NV-1] = '{
        '{1'b1, 4'd10, 1'b0, 64'd0,   64'd10, 1'b0},  // R2 nominal step
        '{1'b1, 4'd0,  1'b0, 64'd0,   64'd11, 1'b0},  // R3 zero step -> 1
        '{1'b0, 4'd5,  1'b0, 64'd0,   64'd11, 1'b0},  // R4 hold
        '{1'b0, 4'd0,  1'b1, 64'd20,  64'd11, 1'b0},  // R6 arm compare
        '{1'b1, 4'd9,  1'b0, 64'd0,   64'd20, 1'b1},  // R5 equal raises
        '{1'b1, 4'd15, 1'b0, 64'd0,   64'd35, 1'b1},  // R5 past stays high
        '{1'b0, 4'd0,  1'b1, 64'd100, 64'd35, 1'b0},  // R6 later value clears
        '{1'b1, 4'd15, 1'b1, 64'd50,  64'd50, 1'b1},  // R9 same edge
        '{1'b0, 4'd0,  1'b1, 64'd0,   64'd50, 1'b1},  // R6 low value raises
        '{1'b0, 4'd0,  1'b1, 64'h8000_0000_0000_0000, 64'd50, 1'b0}, // R8 unsigned
        '{1'b1, 4'd1,  1'b0, 64'd0,   64'd51, 1'b0}   // R2 step of one
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick = 1'b0;
    logic [3:0]  step = '0;
    logic        we = 1'b0;
    logic [63:0] wdata = '0;
    logic [63:0] time_v;
    logic        irq;

    logic        n_tick = 1'b0;
    logic [3:0]  n_step = '0;
    logic        n_we = 1'b0;
    logic [7:0]  n_wdata = '0;
    logic [7:0]  n_time;
    logic        n_irq;

    int vectors = 0;
    int errors  = 0;
    bit done    = 1'b0;

    always #2 clk = ~clk;

    tbc_timebase u0 (
        .clk(clk), .rst(rst), .tick_i(tick), .step_i(step),
        .cmp_we_i(we), .cmp_wdata_i(wdata),
        .time_o(time_v), .sup_tmr_irq_o(irq)
    );

    tbc_timebase #(.TIME_W(8), .STEP_W(4)) u1 (
        .clk(clk), .rst(rst), .tick_i(n_tick), .step_i(n_step),
        .cmp_we_i(n_we), .cmp_wdata_i(n_wdata),
        .time_o(n_time), .sup_tmr_irq_o(n_irq)
    );

    task automatic check(input string req, input logic [63:0] act_t,
                         input logic [63:0] exp_t, input logic act_i,
                         input logic exp_i);
        vectors++;
        if (act_t !== exp_t || act_i !== exp_i) begin
            errors++;
            $display("FAIL %s: time=%0d irq=%0b expected time=%0d irq=%0b",
                     req, act_t, act_i, exp_t, exp_i);
        end
    endtask

    task automatic drive(input logic t, input logic [3:0] s,
                         input logic w, input logic [63:0] d);
        @(negedge clk);
        tick = t; step = s; we = w; wdata = d;
        @(posedge clk);
        #1;
        tick = 1'b0; we = 1'b0;
    endtask

    task automatic drive_n(input logic t, input logic [3:0] s,
                           input logic w, input logic [7:0] d);
        @(negedge clk);
        n_tick = t; n_step = s; n_we = w; n_wdata = d;
        @(posedge clk);
        #1;
        n_tick = 1'b0; n_we = 1'b0;
    endtask

    initial begin
        #200000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not finish");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    initial begin
        logic [63:0] m_time;
        logic [63:0] m_cmp;
        logic [7:0]  w;

        repeat (3) @(posedge clk);
        #1;
        check("R1 reset", time_v, 64'd0, irq, 1'b0);
        @(negedge clk);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            drive(VECS[i].tick, VECS[i].step, VECS[i].we, VECS[i].wdata);
            check($sformatf("vector %0d (R2..R9)", i), time_v,
                  VECS[i].exp_time, irq, VECS[i].exp_irq);
        end

        // R2/R3/R5 longer walk against a model built from the requirements
        m_time = 64'd51;
        m_cmp  = 64'd400;
        drive(1'b0, 4'd0, 1'b1, m_cmp);
        check("R6 compare 400", time_v, m_time, irq, 1'b0);
        for (int k = 0; k < 60; k++) begin
            logic [3:0] s;
            s = 4'((k * 7 + 3) % 16);
            drive(1'b1, s, 1'b0, 64'd0);
            m_time = m_time + ((s == 4'd0) ? 64'd1 : 64'(s));
            check("R2 R3 R5 walk", time_v, m_time, irq, m_time >= m_cmp);
        end

        // R1: reset in mid-run restores the reset state
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        #1;
        check("R1 mid-run reset", time_v, 64'd0, irq, 1'b0);
        @(negedge clk);
        rst = 1'b0;
        drive(1'b0, 4'd0, 1'b0, 64'd0);
        check("R1 compare all ones after reset", time_v, 64'd0, irq, 1'b0);

        // R7: wrap on the 8-bit instance (reset compare 255)
        w = 8'd0;
        for (int k = 0; k < 17; k++) begin
            drive_n(1'b1, 4'd15, 1'b0, 8'd0);
            w = w + 8'd15;
        end
        check("R7 at top", {56'd0, n_time}, {56'd0, w}, n_irq, 1'b1);
        drive_n(1'b1, 4'd15, 1'b0, 8'd0);
        check("R7 wrapped", {56'd0, n_time}, 64'd14, n_irq, 1'b0);
        drive_n(1'b0, 4'd0, 1'b1, 8'd10);
        check("R7 irq after wrap", {56'd0, n_time}, 64'd14, n_irq, 1'b1);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule